// File: doc/BRIEF.md
# Scale-Space 3D Non-Maximum Suppressor

This block takes a stream of Hessian-style determinant responses for one image, delivered in raster order. Each pixel carries six responses at once, one for each scale level. Level 0 is the finest filter and level 5 the coarsest; in filter-size terms the levels are 9, 15, 21, 27, 39 and 51, which form two octaves of four intervals. Responses are unsigned. For each scale the block keeps two line buffers and a 3×3 window register. The four interior levels (1 to 4) are tested in parallel every time a sample is accepted. A level counts as an interest point only if it is above a programmable threshold and strictly greater than all 26 neighbours: the 8 around it in its own level, plus the 3×3 patches in the level directly below and the level directly above.

A pixel can yield hits on more than one level in the same cycle. These hits go into a small FIFO in ascending level order and are drained one record per clock. A two-state emitter controls the drain. In `EM_EMPTY` the FIFO holds nothing. Any push moves it to `EM_HOLD`. `EM_HOLD` pops one entry every cycle and returns to `EM_EMPTY` only when the level after that cycle's pushes and pop is zero. Each output record carries the pixel coordinates, the level index and the response value.

Top module: `scale_nms`

## Requirements
- R1: Each reported record gives the candidate's column in `out_x`, its row in `out_y`, its level index (0 = finest of the six) in `out_scale`, and its own response in `out_val`, all valid for the single cycle in which `out_valid` is high.
- R2: A candidate is reported only when its response is strictly greater than every one of its 26 neighbours. A neighbour with an equal value suppresses it.
- R3: A candidate whose response is less than or equal to `thr` is never reported.
- R4: Levels 0 and 5 are never reported, so `out_scale` always lies in 1..4.
- R5: Pixels in column 0, column IMG_W-1, row 0 or the last row are never reported.
- R6: The decision for pixel (x, y) is made when sample (x+1, y+1) is accepted. With an empty FIFO, `out_valid` rises on the third rising edge after that accepting edge.
- R7: When several levels hit at the same pixel, every hit is emitted, one per cycle and in ascending level order. Records of different pixels come out in raster order.
- R8: Cycles with `in_valid` low have no effect, whatever `in_x`, `in_y` and `in_det` carry.
- R9: While `rst` is high, and on the first cycle after it, `out_valid` is low and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the current input sample |
| in_x | input | XW = $clog2(IMG_W) | Column of the sample |
| in_y | input | YW | Row of the sample |
| in_det | input | 6*DW | Six responses; level k occupies bits [k*DW +: DW] |
| thr | input | DW | Detection threshold |
| out_valid | output | 1 | Record strobe |
| out_x | output | XW | Candidate column |
| out_y | output | YW | Candidate row |
| out_scale | output | 3 | Candidate level index, 1..4 |
| out_val | output | DW | Candidate response |

## Verification
The bench builds the block with IMG_W = 8, DW = 12, YW = 4 and FIFO_DEPTH = 4, and streams frames six rows high. With frames this small, every border column and row, the earliest decision point (sample (2,2)) and the last one fall inside a 48-sample frame. This lets the directed frames place spikes on borders, on outer levels, on pairs of levels at one pixel and on tied neighbours. Random frames with values restricted to 0..15 produce frequent equalities, which exercise the strictness rule. Frames with gaps and junk data on invalid cycles exercise the hold behaviour of the line buffers.

// File: rtl/scale_nms_pkg.sv
package scale_nms_pkg;
    localparam int NUM_LEVELS = 6;
    localparam int FIRST_CAND = 1;
    localparam int NUM_CAND   = NUM_LEVELS - 2;
    localparam int LEVEL_W    = 3;
    localparam int WIN_TAPS   = 9;
    localparam int CENTER_TAP = 4;

    typedef enum logic [0:0] {
        EM_EMPTY,
        EM_HOLD
    } emit_state_t;
endpackage

// File: rtl/nms_window.sv
// Two line buffers plus a 3x3 register window for one scale level.
// After a sample (x, y) is accepted, tap 4 holds pixel (x-1, y-1).
module nms_window
    import scale_nms_pkg::*;
#(
    parameter int DW    = 16,
    parameter int IMG_W = 64,
    parameter int XW    = 6
) (
    input  logic                   clk,
    input  logic                   in_valid,
    input  logic [XW-1:0]          in_x,
    input  logic [DW-1:0]          din,
    output logic [WIN_TAPS*DW-1:0] win
);
    logic [DW-1:0] line_prev  [IMG_W];
    logic [DW-1:0] line_older [IMG_W];
    logic [DW-1:0] tap [3][3];

    always_ff @(posedge clk) begin
        if (in_valid) begin
            line_older[in_x] <= line_prev[in_x];
            line_prev[in_x]  <= din;
            for (int r = 0; r < 3; r++) begin
                tap[r][0] <= tap[r][1];
                tap[r][1] <= tap[r][2];
            end
            tap[0][2] <= line_older[in_x];
            tap[1][2] <= line_prev[in_x];
            tap[2][2] <= din;
        end
    end

    always_comb begin
        for (int r = 0; r < 3; r++) begin
            for (int c = 0; c < 3; c++) begin
                win[(r*3+c)*DW +: DW] = tap[r][c];
            end
        end
    end
endmodule

// File: rtl/nms_peak.sv
// Combinational 3x3x3 strict-maximum test against a threshold.
module nms_peak
    import scale_nms_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [WIN_TAPS*DW-1:0] below,
    input  logic [WIN_TAPS*DW-1:0] here,
    input  logic [WIN_TAPS*DW-1:0] above,
    input  logic [DW-1:0]          thr,
    output logic                   is_peak
);
    logic [DW-1:0] center;

    always_comb begin
        center  = here[CENTER_TAP*DW +: DW];
        is_peak = (center > thr);
        for (int t = 0; t < WIN_TAPS; t++) begin
            if (center <= below[t*DW +: DW]) is_peak = 1'b0;
            if (center <= above[t*DW +: DW]) is_peak = 1'b0;
            if (t != CENTER_TAP && center <= here[t*DW +: DW]) is_peak = 1'b0;
        end
    end
endmodule

// File: rtl/nms_emit.sv
// Multi-push, single-pop record queue; pushes land in ascending level order.
module nms_emit
    import scale_nms_pkg::*;
#(
    parameter int DW    = 16,
    parameter int XW    = 6,
    parameter int YW    = 10,
    parameter int DEPTH = 4,
    parameter int CW    = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_CAND-1:0]    push_mask,
    input  logic [XW-1:0]          push_x,
    input  logic [YW-1:0]          push_y,
    input  logic [NUM_CAND*DW-1:0] push_val,
    output logic                   out_valid,
    output logic [XW-1:0]          out_x,
    output logic [YW-1:0]          out_y,
    output logic [LEVEL_W-1:0]     out_scale,
    output logic [DW-1:0]          out_val,
    output logic [CW-1:0]          level,
    output logic [CW-1:0]          incoming
);
    localparam int PW = $clog2(DEPTH);

    logic [XW-1:0]      mem_x [DEPTH];
    logic [YW-1:0]      mem_y [DEPTH];
    logic [LEVEL_W-1:0] mem_s [DEPTH];
    logic [DW-1:0]      mem_v [DEPTH];

    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [PW-1:0] slot [NUM_CAND];
    logic [CW-1:0] level_nx;
    logic          pop;
    emit_state_t   state, state_nx;

    always_comb begin
        incoming = '0;
        for (int k = 0; k < NUM_CAND; k++) begin
            slot[k]  = wr_ptr + incoming[PW-1:0];
            incoming = incoming + CW'(push_mask[k]);
        end
    end

    assign pop      = (state == EM_HOLD);
    assign level_nx = level + incoming - CW'(pop);

    always_comb begin
        state_nx = state;
        unique case (state)
            EM_EMPTY: state_nx = (incoming != '0) ? EM_HOLD : EM_EMPTY;
            EM_HOLD:  state_nx = (level_nx != '0) ? EM_HOLD : EM_EMPTY;
            default:  state_nx = EM_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= EM_EMPTY;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NUM_CAND; k++) begin
            if (push_mask[k]) begin
                mem_x[slot[k]] <= push_x;
                mem_y[slot[k]] <= push_y;
                mem_s[slot[k]] <= LEVEL_W'(k + FIRST_CAND);
                mem_v[slot[k]] <= push_val[k*DW +: DW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            wr_ptr <= wr_ptr + incoming[PW-1:0];
            rd_ptr <= rd_ptr + PW'(pop);
            level  <= level_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_x     <= '0;
            out_y     <= '0;
            out_scale <= '0;
            out_val   <= '0;
        end else begin
            out_valid <= pop;
            if (pop) begin
                out_x     <= mem_x[rd_ptr];
                out_y     <= mem_y[rd_ptr];
                out_scale <= mem_s[rd_ptr];
                out_val   <= mem_v[rd_ptr];
            end
        end
    end
endmodule

// File: rtl/scale_nms.sv
module scale_nms
    import scale_nms_pkg::*;
#(
    parameter int  DW         = 16,
    parameter int  IMG_W      = 64,
    parameter int  YW         = 10,
    parameter int  FIFO_DEPTH = 4,
    localparam int XW         = $clog2(IMG_W),
    localparam int CW         = $clog2(FIFO_DEPTH) + 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [XW-1:0]            in_x,
    input  logic [YW-1:0]            in_y,
    input  logic [NUM_LEVELS*DW-1:0] in_det,
    input  logic [DW-1:0]            thr,
    output logic                     out_valid,
    output logic [XW-1:0]            out_x,
    output logic [YW-1:0]            out_y,
    output logic [LEVEL_W-1:0]       out_scale,
    output logic [DW-1:0]            out_val
);
    logic [WIN_TAPS*DW-1:0] win [NUM_LEVELS];
    logic [NUM_CAND-1:0]    peak;

    logic                   s1_v;
    logic [XW-1:0]          s1_x;
    logic [YW-1:0]          s1_y;
    logic [NUM_CAND-1:0]    s2_hit;
    logic [NUM_CAND*DW-1:0] s2_val;
    logic [XW-1:0]          s2_x;
    logic [YW-1:0]          s2_y;
    logic [CW-1:0]          q_level, q_incoming;

    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_win
        nms_window #(.DW(DW), .IMG_W(IMG_W), .XW(XW)) u_win (
            .clk     (clk),
            .in_valid(in_valid),
            .in_x    (in_x),
            .din     (in_det[l*DW +: DW]),
            .win     (win[l])
        );
    end

    // Stage 1: window registers settle; candidate is (x-1, y-1).
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v <= 1'b0;
            s1_x <= '0;
            s1_y <= '0;
        end else begin
            s1_v <= in_valid && (in_x >= XW'(2)) && (in_y >= YW'(2));
            s1_x <= in_x - XW'(1);
            s1_y <= in_y - YW'(1);
        end
    end

    for (genvar c = 0; c < NUM_CAND; c++) begin : g_cand
        nms_peak #(.DW(DW)) u_peak (
            .below  (win[c]),
            .here   (win[c+1]),
            .above  (win[c+2]),
            .thr    (thr),
            .is_peak(peak[c])
        );
    end

    // Stage 2: registered decisions for the four interior levels.
    always_ff @(posedge clk) begin
        if (rst) begin
            s2_hit <= '0;
            s2_val <= '0;
            s2_x   <= '0;
            s2_y   <= '0;
        end else begin
            s2_hit <= s1_v ? peak : '0;
            s2_x   <= s1_x;
            s2_y   <= s1_y;
            for (int c = 0; c < NUM_CAND; c++) begin
                s2_val[c*DW +: DW] <= win[c+1][CENTER_TAP*DW +: DW];
            end
        end
    end

    nms_emit #(
        .DW(DW), .XW(XW), .YW(YW), .DEPTH(FIFO_DEPTH), .CW(CW)
    ) u_emit (
        .clk      (clk),
        .rst      (rst),
        .push_mask(s2_hit),
        .push_x   (s2_x),
        .push_y   (s2_y),
        .push_val (s2_val),
        .out_valid(out_valid),
        .out_x    (out_x),
        .out_y    (out_y),
        .out_scale(out_scale),
        .out_val  (out_val),
        .level    (q_level),
        .incoming (q_incoming)
    );
endmodule

// File: rtl/scale_nms_chk.sv
module scale_nms_chk
    import scale_nms_pkg::*;
#(
    parameter int  DW         = 16,
    parameter int  IMG_W      = 64,
    parameter int  YW         = 10,
    parameter int  FIFO_DEPTH = 4,
    localparam int XW         = $clog2(IMG_W),
    localparam int CW         = $clog2(FIFO_DEPTH) + 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic [DW-1:0]          thr,
    input logic                   out_valid,
    input logic [XW-1:0]          out_x,
    input logic [YW-1:0]          out_y,
    input logic [LEVEL_W-1:0]     out_scale,
    input logic [NUM_CAND-1:0]    s2_hit,
    input logic [NUM_CAND*DW-1:0] s2_val,
    input logic [CW-1:0]          q_level,
    input logic [CW-1:0]          q_incoming
);
    logic was_rst = 1'b0;

    always @(posedge clk) begin
        if (was_rst && !rst) begin
            p_reset_idle_r9: assert (!out_valid && q_level == '0)
                else $error("R9: output or queue busy right after reset");
        end
        was_rst <= rst;
    end

    p_scale_range_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_scale >= LEVEL_W'(1) && out_scale <= LEVEL_W'(4)))
        else $error("R4: outer level reported");

    p_border_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_x >= XW'(1) && out_x <= XW'(IMG_W-2) && out_y >= YW'(1)))
        else $error("R5: border pixel reported");

    p_level_order_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid) && out_x == $past(out_x) && out_y == $past(out_y))
        |-> (out_scale > $past(out_scale)))
        else $error("R7: levels of one pixel out of order");

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (int'(q_level) + int'(q_incoming)) <= (FIFO_DEPTH + ((q_level != '0) ? 1 : 0)))
        else $error("R7: record queue overflow");

    for (genvar c = 0; c < NUM_CAND; c++) begin : g_thr
        p_over_thr_r3: assert property (@(posedge clk) disable iff (rst)
            s2_hit[c] |-> (s2_val[c*DW +: DW] > $past(thr)))
            else $error("R3: hit at or below threshold");
    end
endmodule

bind scale_nms scale_nms_chk #(
    .DW(DW), .IMG_W(IMG_W), .YW(YW), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .thr       (thr),
    .out_valid (out_valid),
    .out_x     (out_x),
    .out_y     (out_y),
    .out_scale (out_scale),
    .s2_hit    (s2_hit),
    .s2_val    (s2_val),
    .q_level   (q_level),
    .q_incoming(q_incoming)
);

// File: tb/sim_scale_nms.sv
module sim_scale_nms;
    import scale_nms_pkg::*;

    localparam int DW = 12, IMG_W = 8, YW = 4, FIFO_DEPTH = 4, H = 6;
    localparam int XW = $clog2(IMG_W);

    logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
    logic [XW-1:0] in_x = '0;
    logic [YW-1:0] in_y = '0;
    logic [NUM_LEVELS*DW-1:0] in_det = '0;
    logic [DW-1:0] thr = '0;
    logic out_valid;
    logic [XW-1:0] out_x;
    logic [YW-1:0] out_y;
    logic [LEVEL_W-1:0] out_scale;
    logic [DW-1:0] out_val;

    always #10 clk = ~clk;

    scale_nms #(.DW(DW), .IMG_W(IMG_W), .YW(YW), .FIFO_DEPTH(FIFO_DEPTH)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
        .in_det(in_det), .thr(thr), .out_valid(out_valid), .out_x(out_x),
        .out_y(out_y), .out_scale(out_scale), .out_val(out_val)
    );

    typedef struct {int w; int x; int y; int s; int v;} rec_t;
    int    fr [NUM_LEVELS][H][IMG_W];
    rec_t  expq [$];
    int    seen_s [$];
    int    ecount = 0, n_checks = 0, n_fail = 0, ph_outs = 0;
    int    last_out_edge = 0, spike_cap = 0;
    string cur_req = "R9";
    bit    done = 0;

    // Reference: 26-neighbour strict maximum above threshold, levels 1..4.
    task automatic model_capture(input int x, input int y);
        int cx, cy, c;
        bit ok;
        rec_t r;
        if (x >= 2 && y >= 2) begin
            cx = x - 1; cy = y - 1;
            for (int s = 1; s <= 4; s++) begin
                c  = fr[s][cy][cx];
                ok = (c > int'(thr));
                for (int ds = -1; ds <= 1; ds++)
                    for (int dy = -1; dy <= 1; dy++)
                        for (int dx = -1; dx <= 1; dx++)
                            if (!(ds == 0 && dy == 0 && dx == 0) &&
                                fr[s+ds][cy+dy][cx+dx] >= c) ok = 0;
                if (ok) begin
                    r.w = ecount + 2; r.x = cx; r.y = cy; r.s = s; r.v = c;
                    expq.push_back(r);
                end
            end
        end
    endtask

    task automatic tick();
        rec_t e;
        bit ev;
        @(posedge clk);
        ecount++;
        if (!rst && in_valid) model_capture(int'(in_x), int'(in_y));
        ev = 0;
        if (expq.size() > 0 && expq[0].w < ecount) begin
            e = expq.pop_front();
            ev = 1;
        end
        @(negedge clk);
        n_checks++;
        if (ev) begin
            if (!(out_valid && int'(out_x) == e.x && int'(out_y) == e.y &&
                  int'(out_scale) == e.s && int'(out_val) == e.v)) begin
                n_fail++;
                $display("FAIL %s: got v=%0d x=%0d y=%0d s=%0d val=%0d, expected v=1 x=%0d y=%0d s=%0d val=%0d",
                         cur_req, out_valid, out_x, out_y, out_scale, out_val, e.x, e.y, e.s, e.v);
            end
        end else if (out_valid) begin
            n_fail++;
            $display("FAIL %s: got v=1 x=%0d y=%0d s=%0d val=%0d, expected v=0",
                     cur_req, out_x, out_y, out_scale, out_val);
        end
        if (out_valid) begin
            ph_outs++;
            seen_s.push_back(int'(out_scale));
            last_out_edge = ecount;
        end
    endtask

    task automatic clear_frame();
        for (int l = 0; l < NUM_LEVELS; l++)
            for (int y = 0; y < H; y++)
                for (int x = 0; x < IMG_W; x++) fr[l][y][x] = 0;
    endtask

    task automatic rand_frame(input int maxv);
        for (int l = 0; l < NUM_LEVELS; l++)
            for (int y = 0; y < H; y++)
                for (int x = 0; x < IMG_W; x++) fr[l][y][x] = int'($urandom_range(0, maxv));
    endtask

    task automatic send_frame(input int gap_pct);
        ph_outs = 0;
        seen_s.delete();
        for (int y = 0; y < H; y++) begin
            for (int x = 0; x < IMG_W; x++) begin
                while (int'($urandom_range(0, 99)) < gap_pct) begin
                    in_valid = 1'b0;
                    in_x     = XW'($urandom);
                    in_y     = YW'($urandom);
                    in_det   = {NUM_LEVELS{DW'($urandom)}};
                    tick();
                end
                in_valid = 1'b1;
                in_x = XW'(x);
                in_y = YW'(y);
                for (int l = 0; l < NUM_LEVELS; l++) in_det[l*DW +: DW] = DW'(fr[l][y][x]);
                tick();
                if (x == 4 && y == 3) spike_cap = ecount;
            end
        end
        in_valid = 1'b0;
        repeat (8) tick();
    endtask

    task automatic expect_count(input string req, input int exp);
        n_checks++;
        if (ph_outs != exp) begin
            n_fail++;
            $display("FAIL %s: %0d records, expected %0d", req, ph_outs, exp);
        end
    endtask

    task automatic expect_equal(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d, expected %0d", req, act, exp);
        end
    endtask

    initial begin
        // R9: reset state
        cur_req = "R9";
        repeat (3) tick();
        rst = 1'b0;
        repeat (2) tick();

        // R1 and R6: single spike on level 2 at (3,2)
        cur_req = "R1";
        thr = DW'(10);
        clear_frame();
        fr[2][2][3] = 100;
        send_frame(0);
        expect_count("R1", 1);
        expect_equal("R6 latency", last_out_edge - spike_cap, 3);

        // R3: equal to threshold rejected, one above accepted
        cur_req = "R3";
        thr = DW'(100);
        send_frame(0);
        expect_count("R3 at threshold", 0);
        thr = DW'(99);
        send_frame(0);
        expect_count("R3 above threshold", 1);

        // R4: spikes on outer levels only
        cur_req = "R4";
        thr = DW'(10);
        clear_frame();
        fr[0][2][3] = 100;
        fr[5][3][5] = 100;
        send_frame(0);
        expect_count("R4", 0);

        // R5: border spikes ignored, inner corners kept
        cur_req = "R5";
        clear_frame();
        fr[2][3][0] = 50; fr[2][3][7] = 50; fr[2][0][3] = 50; fr[2][5][3] = 50;
        fr[3][1][1] = 100; fr[3][4][6] = 100;
        send_frame(0);
        expect_count("R5", 2);

        // R7: two hits at each of two pixels, ascending level order
        cur_req = "R7";
        clear_frame();
        fr[1][3][4] = 50; fr[3][3][4] = 60;
        fr[2][1][5] = 70; fr[4][1][5] = 80;
        send_frame(0);
        expect_count("R7", 4);
        if (seen_s.size() == 4) begin
            expect_equal("R7 order 0", seen_s[0], 2);
            expect_equal("R7 order 1", seen_s[1], 4);
            expect_equal("R7 order 2", seen_s[2], 1);
            expect_equal("R7 order 3", seen_s[3], 3);
        end

        // R2: ties within and across levels suppress
        cur_req = "R2";
        clear_frame();
        fr[2][3][3] = 40; fr[2][3][4] = 40;
        fr[1][1][6] = 40; fr[2][2][5] = 40;
        send_frame(0);
        expect_count("R2 ties", 0);

        // R8: gaps carrying junk do not disturb the stream
        cur_req = "R8";
        clear_frame();
        fr[2][2][3] = 100;
        send_frame(40);
        expect_count("R8", 1);

        // R2: random frames, dense ties and wide values, with gaps
        cur_req = "R2";
        for (int f = 0; f < 12; f++) begin
            thr = DW'($urandom_range(0, 6));
            rand_frame((f < 6) ? 15 : 4095);
            send_frame((f % 2 == 0) ? 0 : 30);
        end
        expect_equal("R2 queue drained", expq.size(), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (R6): run did not finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule